// File: doc/BRIEF.md
# Embedded-Clock Serial Link

This block moves parallel words over one wire in both halves of a point-to-point link. The transmit half takes a word through a valid/ready handshake and loads it into a shift register. It then drives a burst onto the line: one bit time high, one bit time low, and then the data bits, least-significant first. The line then stays low for at least one bit time. Between bursts the line rests low.

The receive half runs on its own local clock at sixteen samples per nominal bit. The line passes through a two-stage synchronizer. The receiver waits for a low-to-high transition and counts half a bit to the middle of the opening high bit, where it confirms the line is still high. From there it samples once per bit. The data bits are shifted in one at a time and the finished word is handed over in parallel with a one-cycle strobe. Each burst's leading edge re-times the receiver, so a local clock that is up to five percent off still lands every sample inside its bit.

Edge hunting is only re-enabled after the last data bit has been sampled, so transitions inside the data never restart the receiver. A start edge whose high bit has already collapsed by mid-bit is treated as noise: the burst is discarded and an error strobe is raised.

Top module: `ecl_link`

## Requirements
- R1: After reset, `tx_ready` is 1, `serial_out` is 0, and `rx_valid` and `rx_frame_err` are 0; while the transmitter is ready, the line is low.
- R2: A word is taken on a `tx_clk` edge where `tx_valid` and `tx_ready` are both 1. `serial_out` is 1 from that edge on. `tx_ready` stays 0 until the line has spent one full bit time low after the last data bit.
- R3: A burst is one bit time of 1, one bit time of 0, then the `W` data bits with bit 0 first, then one bit time of 0. Each bit time is `OVS` `tx_clk` cycles, and the line changes only at bit boundaries.
- R4: The receiver starts a burst only on a 0-to-1 change of the synchronized line while it is hunting for an edge.
- R5: `HALF` = `OVS`/2 samples after the start edge, the receiver checks the line. If it is 0, the burst is dropped, `rx_frame_err` is 1 for exactly one cycle, and `rx_valid` does not rise for that burst.
- R6: Each data bit is sampled `OVS` samples after the previous one. After the last data bit, the word appears on `rx_data` (bit 0 first received) with `rx_valid` high for one cycle. `rx_data` holds its value until the next strobe.
- R7: Edge hunting resumes only after the last data bit has been sampled, so data transitions never start a new burst.
- R8: Every word is recovered intact with the receive clock at the nominal rate and at 5 percent above or below it.
- R9: With `tx_valid` held high for a stream of words, every word is sent and recovered in order, with none lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tx_clk | input | 1 | Transmit clock, `OVS` cycles per bit |
| tx_rst_n | input | 1 | Transmit reset, active low, asynchronous |
| tx_data | input | W | Word to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Transmitter can take a word |
| serial_out | output | 1 | Serial line driven by the transmitter |
| rx_clk | input | 1 | Receive sampling clock, nominally `OVS` samples per bit |
| rx_rst_n | input | 1 | Receive reset, active low, asynchronous |
| serial_in | input | 1 | Serial line into the receiver |
| rx_data | output | W | Last recovered word |
| rx_valid | output | 1 | One-cycle strobe: `rx_data` is new |
| rx_frame_err | output | 1 | One-cycle strobe: a burst was dropped |

## Verification
Two things can fall in the same receive cycle: the strobe that hands over word N, and the return to edge hunting that must catch the opening edge of word N+1. The bench provokes this by holding `tx_valid` high so bursts follow each other with only the one-bit low gap. It runs this with the receive clock 5 percent slow, where the last-bit sample drifts late toward that gap, and 5 percent fast. The case is judged by comparing each strobed word, in order, against a queue of the words handed to the transmitter, and by checking at the end that the number of words received equals the number sent.

// File: rtl/ecl_pkg.sv
package ecl_pkg;

    typedef enum logic [2:0] {
        TX_IDLE,
        TX_CLKH,
        TX_CLKL,
        TX_DATA,
        TX_GUARD
    } tx_state_e;

    typedef enum logic [1:0] {
        RX_HUNT,
        RX_CHKH,
        RX_BITS
    } rx_state_e;

endpackage

// File: rtl/ecl_tx.sv
module ecl_tx
    import ecl_pkg::*;
#(
    parameter int W   = 6,
    parameter int OVS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] data_i,
    input  logic         valid_i,
    output logic         ready_o,
    output logic         line_o
);

    localparam int CW = $clog2(OVS);
    localparam int BW = $clog2(W);

    typedef struct packed {
        tx_state_e     st;
        logic [W-1:0]  sh;
        logic [CW-1:0] tick;
        logic [BW-1:0] bidx;
        logic          line;
    } tx_regs_t;

    tx_regs_t q, d;

    always_comb begin
        d = q;
        if (q.st == TX_IDLE) begin
            d.tick = '0;
            if (valid_i) begin
                d.st   = TX_CLKH;
                d.sh   = data_i;
                d.line = 1'b1;
            end
        end else if (q.tick != CW'(OVS - 1)) begin
            d.tick = q.tick + 1'b1;
        end else begin
            d.tick = '0;
            unique case (q.st)
                TX_CLKH: begin
                    d.st   = TX_CLKL;
                    d.line = 1'b0;
                end
                TX_CLKL: begin
                    d.st   = TX_DATA;
                    d.line = q.sh[0];
                    d.bidx = '0;
                end
                TX_DATA: begin
                    if (q.bidx == BW'(W - 1)) begin
                        d.st   = TX_GUARD;
                        d.line = 1'b0;
                    end else begin
                        d.sh   = q.sh >> 1;
                        d.line = q.sh[1];
                        d.bidx = q.bidx + 1'b1;
                    end
                end
                TX_GUARD: d.st = TX_IDLE;
                default:  d.st = TX_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: TX_IDLE, sh: '0, tick: '0, bidx: '0, line: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign ready_o = (q.st == TX_IDLE);
    assign line_o  = q.line;

    AST_TX_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ready_o |-> !line_o); // R1
    AST_TX_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_i && ready_o) |=> (line_o && !ready_o)); // R2
    AST_TX_BIT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != TX_IDLE && q.tick != '0) |-> $stable(line_o)); // R3

endmodule

// File: rtl/ecl_sync.sv
module ecl_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);

    logic [STAGES-1:0] ff_q, ff_d;

    always_comb begin
        ff_d = {ff_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ff_q <= '0;
        end else begin
            ff_q <= ff_d;
        end
    end

    assign q_o = ff_q[STAGES-1];

endmodule

// File: rtl/ecl_rx.sv
module ecl_rx
    import ecl_pkg::*;
#(
    parameter int W   = 6,
    parameter int OVS = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         s_i,
    output logic [W-1:0] data_o,
    output logic         valid_o,
    output logic         err_o
);

    localparam int CW   = $clog2(OVS);
    localparam int BW   = $clog2(W + 1);
    localparam int HALF = OVS / 2;

    typedef struct packed {
        rx_state_e     st;
        logic          prev;
        logic [CW-1:0] cnt;
        logic [BW-1:0] bidx;
        logic [W-1:0]  sh;
        logic [W-1:0]  dout;
        logic          vld;
        logic          err;
    } rx_regs_t;

    rx_regs_t q, d;

    always_comb begin
        d      = q;
        d.prev = s_i;
        d.vld  = 1'b0;
        d.err  = 1'b0;
        unique case (q.st)
            RX_HUNT: begin
                if (!q.prev && s_i) begin
                    d.st  = RX_CHKH;
                    d.cnt = '0;
                end
            end
            RX_CHKH: begin
                if (q.cnt == CW'(HALF - 1)) begin
                    d.cnt = '0;
                    if (s_i) begin
                        d.st   = RX_BITS;
                        d.bidx = '0;
                    end else begin
                        d.st  = RX_HUNT;
                        d.err = 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            RX_BITS: begin
                if (q.cnt == CW'(OVS - 1)) begin
                    d.cnt = '0;
                    if (q.bidx != '0) begin
                        d.sh = {s_i, q.sh[W-1:1]};
                    end
                    if (q.bidx == BW'(W)) begin
                        d.st   = RX_HUNT;
                        d.dout = {s_i, q.sh[W-1:1]};
                        d.vld  = 1'b1;
                    end else begin
                        d.bidx = q.bidx + 1'b1;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.st = RX_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: RX_HUNT, prev: 1'b0, cnt: '0, bidx: '0,
                   sh: '0, dout: '0, vld: 1'b0, err: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign data_o  = q.dout;
    assign valid_o = q.vld;
    assign err_o   = q.err;

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o); // R6
    AST_RX_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable(data_o)); // R6
    AST_RX_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |=> !err_o); // R5
    AST_RX_ERR_NO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_o && valid_o)); // R5
    AST_RX_NO_EARLY_REARM: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == RX_BITS) |=> (q.st != RX_CHKH)); // R7

endmodule

// File: rtl/ecl_link.sv
module ecl_link #(
    parameter int W       = 6,
    parameter int OVS     = 16,
    parameter int SYNC_FF = 2
) (
    input  logic         tx_clk,
    input  logic         tx_rst_n,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         tx_ready,
    output logic         serial_out,
    input  logic         rx_clk,
    input  logic         rx_rst_n,
    input  logic         serial_in,
    output logic [W-1:0] rx_data,
    output logic         rx_valid,
    output logic         rx_frame_err
);

    logic line_sync;

    ecl_tx #(.W(W), .OVS(OVS)) u_tx (
        .clk     (tx_clk),
        .rst_n   (tx_rst_n),
        .data_i  (tx_data),
        .valid_i (tx_valid),
        .ready_o (tx_ready),
        .line_o  (serial_out)
    );

    ecl_sync #(.STAGES(SYNC_FF)) u_sync (
        .clk   (rx_clk),
        .rst_n (rx_rst_n),
        .d_i   (serial_in),
        .q_o   (line_sync)
    );

    ecl_rx #(.W(W), .OVS(OVS)) u_rx (
        .clk     (rx_clk),
        .rst_n   (rx_rst_n),
        .s_i     (line_sync),
        .data_o  (rx_data),
        .valid_o (rx_valid),
        .err_o   (rx_frame_err)
    );

endmodule

// File: tb/test_ecl_link.sv
`timescale 1ns/1ps
module test_ecl_link;

    localparam int W   = 6;
    localparam int OVS = 16;
    localparam logic [W-1:0] VEC [12] = '{
        6'h00, 6'h3F, 6'h15, 6'h2A, 6'h01, 6'h20,
        6'h3E, 6'h1F, 6'h33, 6'h0C, 6'h27, 6'h18
    };

    logic         tx_clk = 1'b0, rx_clk = 1'b0;
    logic         tx_rst_n = 1'b0, rx_rst_n = 1'b0;
    logic [W-1:0] tx_data = '0;
    logic         tx_valid = 1'b0;
    logic         tx_ready, serial_out;
    logic         inject = 1'b0;
    logic         serial_in;
    logic [W-1:0] rx_data;
    logic         rx_valid, rx_frame_err;
    realtime      rx_half = 5.0;

    assign serial_in = serial_out | inject;

    always #5 tx_clk = ~tx_clk;
    always #(rx_half) rx_clk = ~rx_clk;

    ecl_link #(.W(W), .OVS(OVS)) i_ecl_link (
        .tx_clk(tx_clk), .tx_rst_n(tx_rst_n), .tx_data(tx_data),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .serial_out(serial_out),
        .rx_clk(rx_clk), .rx_rst_n(rx_rst_n), .serial_in(serial_in),
        .rx_data(rx_data), .rx_valid(rx_valid), .rx_frame_err(rx_frame_err)
    );

    int n_chk = 0, n_fail = 0;
    int m_chk = 0, m_fail = 0;
    int n_sent = 0, n_rx = 0, n_err = 0;
    logic [W-1:0] exp_q [$];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Receive monitor: every strobed word against the queue (R6 R8 R9)
    always @(negedge rx_clk) begin
        if (rx_rst_n && rx_valid) begin
            n_rx++;
            m_chk++;
            if (exp_q.size() == 0) begin
                m_fail++;
                $display("FAIL R6 R8: actual word %0d expected none", rx_data);
            end else begin
                automatic logic [W-1:0] e = exp_q.pop_front();
                if (rx_data !== e) begin
                    m_fail++;
                    $display("FAIL R6 R8: actual %0d expected %0d", rx_data, e);
                end
            end
        end
        if (rx_rst_n && rx_frame_err) n_err++;
    end

    task automatic push(input logic [W-1:0] w);
        tx_data  = w;
        tx_valid = 1'b1;
        while (!tx_ready) @(negedge tx_clk);
        exp_q.push_back(w);
        n_sent++;
        @(negedge tx_clk);
    endtask

    task automatic drain();
        while (exp_q.size() != 0) @(negedge tx_clk);
        repeat (60) @(negedge tx_clk);
    endtask

    task automatic summary(input int extra);
        $display("[TB] %0d tests run, %0d failed",
                 n_chk + m_chk + extra, n_fail + m_fail + extra);
    endtask

    initial begin
        repeat (150000) @(posedge tx_clk);
        $display("FAIL watchdog: actual timeout expected completion");
        summary(1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge tx_clk);
        tx_rst_n = 1'b1;
        rx_rst_n = 1'b1;
        @(negedge tx_clk);
        // R1: reset state
        chk(tx_ready === 1'b1, "R1 tx_ready", int'(tx_ready), 1);
        chk(serial_out === 1'b0, "R1 serial_out", int'(serial_out), 0);
        chk(rx_valid === 1'b0, "R1 rx_valid", int'(rx_valid), 0);
        chk(rx_frame_err === 1'b0, "R1 rx_frame_err", int'(rx_frame_err), 0);

        // R3 R2: burst shape for 6'b101101, sampled mid-bit at negedges
        begin
            automatic logic [W-1:0] w = 6'b101101;
            tx_data  = w;
            tx_valid = 1'b1;
            exp_q.push_back(w);
            n_sent++;
            @(negedge tx_clk);
            tx_valid = 1'b0;
            for (int k = 1; k <= 150; k++) begin
                automatic logic ev;
                if (k > 1) @(negedge tx_clk);
                if (k <= 16)       ev = 1'b1;
                else if (k <= 32)  ev = 1'b0;
                else if (k <= 128) ev = w[(k - 33) / 16];
                else               ev = 1'b0;
                if (k % 16 == 8)
                    chk(serial_out === ev, "R3 line shape", int'(serial_out), int'(ev));
                if (k == 140)
                    chk(tx_ready === 1'b0, "R2 busy in gap", int'(tx_ready), 0);
                if (k == 146)
                    chk(tx_ready === 1'b1, "R2 ready after gap", int'(tx_ready), 1);
            end
        end
        drain();
        chk(rx_data === 6'b101101, "R6 hold after strobe", int'(rx_data), 45);

        // Vector table at nominal rate, alternating patterns exercise R4 R7
        for (int i = 0; i < 12; i++) begin
            push(VEC[i]);
            tx_valid = 1'b0;
            repeat (5) @(negedge tx_clk);
        end
        drain();

        // R5: glitch on the idle line, too short to survive to mid-bit
        begin
            automatic int e0 = n_err, v0 = n_rx;
            inject = 1'b1;
            repeat (3) @(negedge tx_clk);
            inject = 1'b0;
            repeat (60) @(negedge tx_clk);
            chk(n_err == e0 + 1, "R5 frame error pulse", n_err, e0 + 1);
            chk(n_rx == v0, "R5 no word on error", n_rx, v0);
        end
        push(6'h2D);
        tx_valid = 1'b0;
        drain();

        // R8 R9: streams with tx_valid held, rx clock -5%, +5%, nominal
        for (int p = 0; p < 3; p++) begin
            rx_half = (p == 0) ? 5.0 * 1.05 : ((p == 1) ? 5.0 / 1.05 : 5.0);
            repeat (40) @(negedge tx_clk);
            @(negedge tx_clk);
            for (int i = 0; i < 16; i++) push(W'($urandom));
            tx_valid = 1'b0;
            drain();
            chk(exp_q.size() == 0, "R8 R9 all recovered", exp_q.size(), 0);
        end

        chk(n_rx == n_sent, "R9 word count", n_rx, n_sent);
        chk(n_err == 1, "R4 R7 no spurious bursts", n_err, 1);
        summary(0);
        $finish;
    end

endmodule